// File: doc/BRIEF.md
# DMA Leak and Antagonist Detector

This block watches cache and I/O event counts from a set of traffic sources, one evaluation per sampling period. During a period, a counter front end delivers one record per source over a valid/ready stream. A record holds the last-level cache hit and miss counts, the mid-level cache hit and miss counts, the hit and miss counts of the cache ways reserved for DMA injection, the source's I/O throughput, and whether the source is a storage device. When the period closes, the block turns the latest record of each source into two flags. The leak flag asks that DMA cache injection be switched off for that source's port. The antagonist flag marks a source that is thrashing the cache.

All ratios are compared without division, as `part * 100 > threshold * whole` in integer arithmetic. The comparison is strict, so a source with no accesses never qualifies. Periods are counted in pulses of a one-second timebase input. After a programmable run of steady periods, the block raises a revert output for a programmable number of periods. This lets the partition allocator return to its initial layout and look for a change of workload phase. Records taken while revert is high never change the flags.

Seven configuration registers are written through a plain write strobe. Addresses 0 to 3 hold 7-bit thresholds taken from `cfg_wdata[6:0]`: injection-way miss (reset 40), LLC miss for leak (reset 40), storage throughput share (reset 35) and antagonist miss (reset 90). Addresses 4 to 6 hold 16-bit counts: timebase pulses per period (reset 1), steady periods before a probe (reset 10) and probe periods (reset 1). A count of 0 acts as 1.

Top module: `lam_leak_monitor`

## Requirements
- R1: A source is leak-flagged only if its storage bit is 1, its injection-way misses×100 > inj_thr×(inj hits+misses) and its LLC misses×100 > llc_thr×(LLC hits+misses). The system share condition of R2 must also hold, so all conditions are required together. The reset thresholds are 40 and 40.
- R2: The share condition holds when (sum of io over sources whose latest record has storage=1)×100 > io_thr×(sum of io over all sources with a record this period). The reset io_thr is 35.
- R3: A source is antagonist-flagged when both its MLC and its LLC miss ratios, compared as in R1, exceed ant_thr. The reset ant_thr is 90. The storage bit has no effect on this flag.
- R4: A source with zero hits and zero misses in a ratio, or with no record in the period, is never flagged, even with a threshold of 0.
- R5: Flags change only on the second rising edge after the closing timebase pulse is sampled. They are visible in the cycle after that edge and hold their value at all other times.
- R6: After stable_len closed periods in the steady phase, revert_part goes high on the same edge that updates the flags. It stays high for probe_len periods and then returns low.
- R7: When a probe period closes, the flags keep their previous values. The next steady period is evaluated normally.
- R8: in_ready is low exactly during the cycle after a closing pulse and high at all other times. A record is taken when in_valid and in_ready are both high. A record taken in the same cycle as the closing pulse belongs to the closing period. A later record for the same source in one period replaces the earlier one.
- R9: After reset the flags and revert_part are 0, in_ready is 1, and the registers hold the reset values given above.
- R10: A period closes on every period_len-th timebase pulse. Pulses that do not close a period leave the flags and in_ready unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| sec_tick | input | 1 | one-cycle timebase pulse |
| cfg_we | input | 1 | configuration write strobe |
| cfg_addr | input | 3 | configuration register address |
| cfg_wdata | input | 16 | configuration write data |
| in_valid | input | 1 | record valid |
| in_ready | output | 1 | record accepted when high with in_valid |
| in_src | input | SW | source index |
| in_storage | input | 1 | source is a storage device |
| in_llc_hit | input | CW | LLC hits |
| in_llc_miss | input | CW | LLC misses |
| in_mlc_hit | input | CW | MLC hits |
| in_mlc_miss | input | CW | MLC misses |
| in_inj_hit | input | CW | injection-way hits |
| in_inj_miss | input | CW | injection-way misses |
| in_io | input | IOW | I/O throughput in the period |
| leak_flag | output | NSRC | per-source request to disable cache injection |
| antag_flag | output | NSRC | per-source cache antagonist flag |
| revert_part | output | 1 | probe phase: restore the initial partition |

## Verification
The assertions assume that `in_src` is always below NSRC. They also assume that thresholds do not change between the records of a period and its close, and that the period, steady and probe counts are not rewritten during a probe. The stimulus writes configuration only between periods and only uses valid source indices. It raises `in_valid` for one cycle at a time, and only in cycles where `in_ready` is known to be high. The one exception is the cycle of the closing pulse itself, which the stimulus uses on purpose. The sweeps run each ratio across its full 0 to 100 percent range, including the exact threshold values. A wide steady count keeps the probe phase from interrupting the sweeps until the probe phase is tested on its own.

// File: rtl/lam_pkg.sv
package lam_pkg;
  localparam logic [2:0] CFG_INJ_THR = 3'd0;
  localparam logic [2:0] CFG_LLC_THR = 3'd1;
  localparam logic [2:0] CFG_IO_THR  = 3'd2;
  localparam logic [2:0] CFG_ANT_THR = 3'd3;
  localparam logic [2:0] CFG_PERIOD  = 3'd4;
  localparam logic [2:0] CFG_STABLE  = 3'd5;
  localparam logic [2:0] CFG_PROBE   = 3'd6;

  localparam logic [6:0]  DEF_INJ_THR = 7'd40;
  localparam logic [6:0]  DEF_LLC_THR = 7'd40;
  localparam logic [6:0]  DEF_IO_THR  = 7'd35;
  localparam logic [6:0]  DEF_ANT_THR = 7'd90;
  localparam logic [15:0] DEF_PERIOD  = 16'd1;
  localparam logic [15:0] DEF_STABLE  = 16'd10;
  localparam logic [15:0] DEF_PROBE   = 16'd1;

  typedef enum logic {PH_STEADY = 1'b0, PH_PROBE = 1'b1} phase_e;
endpackage

// File: rtl/lam_ratio_cmp.sv
module lam_ratio_cmp #(
  parameter int W = 17
) (
  input  logic [W-1:0] part,
  input  logic [W-1:0] whole,
  input  logic [6:0]   thr,
  output logic         gt
);
  localparam int PW = W + 7;

  logic [PW-1:0] lhs;
  logic [PW-1:0] rhs;

  // percentage test without a divider: part/whole > thr/100
  assign lhs = PW'(part) * PW'(100);
  assign rhs = PW'(thr) * PW'(whole);
  assign gt  = lhs > rhs;
endmodule

// File: rtl/lam_phase_ctl.sv
module lam_phase_ctl
  import lam_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        close,
  input  logic [15:0] stable_len,
  input  logic [15:0] probe_len,
  output logic        probe
);
  phase_e      ph;
  logic [15:0] cnt;
  logic [16:0] cnt_nx;

  assign cnt_nx = {1'b0, cnt} + 17'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_STEADY;
      cnt <= '0;
    end else if (close) begin
      case (ph)
        PH_STEADY: begin
          if (cnt_nx >= {1'b0, stable_len}) begin
            ph  <= PH_PROBE;
            cnt <= '0;
          end else begin
            cnt <= cnt_nx[15:0];
          end
        end
        default: begin
          if (cnt_nx >= {1'b0, probe_len}) begin
            ph  <= PH_STEADY;
            cnt <= '0;
          end else begin
            cnt <= cnt_nx[15:0];
          end
        end
      endcase
    end
  end

  assign probe = (ph == PH_PROBE);

  // R6: phase only moves at a period close
  assert_probe_entry_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(probe) |-> $past(close));
  assert_probe_exit_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(probe) |-> $past(close));
endmodule

// File: rtl/lam_src_table.sv
module lam_src_table #(
  parameter int NSRC = 4,
  parameter int IOW  = 16,
  parameter int SW   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear,
  input  logic                      wr,
  input  logic [SW-1:0]             src,
  input  logic                      sto_in,
  input  logic                      leak_in,
  input  logic                      ant_in,
  input  logic [IOW-1:0]            io_in,
  output logic [NSRC-1:0]           seen,
  output logic [NSRC-1:0]           sto,
  output logic [NSRC-1:0]           leak_c,
  output logic [NSRC-1:0]           ant_c,
  output logic [NSRC-1:0][IOW-1:0]  io
);
  for (genvar g = 0; g < NSRC; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        seen[g]   <= 1'b0;
        sto[g]    <= 1'b0;
        leak_c[g] <= 1'b0;
        ant_c[g]  <= 1'b0;
        io[g]     <= '0;
      end else if (wr && (src == SW'(g))) begin
        seen[g]   <= 1'b1;
        sto[g]    <= sto_in;
        leak_c[g] <= leak_in;
        ant_c[g]  <= ant_in;
        io[g]     <= io_in;
      end
    end
  end

  // R8: an accepted record is held for its source
  assert_record_lands_R8: assert property (@(posedge clk) disable iff (rst)
    (wr && !clear) |=> seen[$past(src)]);
endmodule

// File: rtl/lam_leak_monitor.sv
module lam_leak_monitor
  import lam_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int CW   = 16,
  parameter int IOW  = 16,
  localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_tick,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [15:0]      cfg_wdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SW-1:0]    in_src,
  input  logic             in_storage,
  input  logic [CW-1:0]    in_llc_hit,
  input  logic [CW-1:0]    in_llc_miss,
  input  logic [CW-1:0]    in_mlc_hit,
  input  logic [CW-1:0]    in_mlc_miss,
  input  logic [CW-1:0]    in_inj_hit,
  input  logic [CW-1:0]    in_inj_miss,
  input  logic [IOW-1:0]   in_io,
  output logic [NSRC-1:0]  leak_flag,
  output logic [NSRC-1:0]  antag_flag,
  output logic             revert_part
);
  localparam int TW   = CW + 1;
  localparam int SUMW = IOW + SW;

  // configuration
  logic [6:0]  thr_inj, thr_llc, thr_io, thr_ant;
  logic [15:0] period_len, stable_len, probe_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_inj    <= DEF_INJ_THR;
      thr_llc    <= DEF_LLC_THR;
      thr_io     <= DEF_IO_THR;
      thr_ant    <= DEF_ANT_THR;
      period_len <= DEF_PERIOD;
      stable_len <= DEF_STABLE;
      probe_len  <= DEF_PROBE;
    end else if (cfg_we) begin
      case (cfg_addr)
        CFG_INJ_THR: thr_inj    <= cfg_wdata[6:0];
        CFG_LLC_THR: thr_llc    <= cfg_wdata[6:0];
        CFG_IO_THR:  thr_io     <= cfg_wdata[6:0];
        CFG_ANT_THR: thr_ant    <= cfg_wdata[6:0];
        CFG_PERIOD:  period_len <= cfg_wdata;
        CFG_STABLE:  stable_len <= cfg_wdata;
        CFG_PROBE:   probe_len  <= cfg_wdata;
        default: ;
      endcase
    end
  end

  // period timing
  logic [15:0] tick_cnt;
  logic [16:0] tick_nx;
  logic        closing;
  logic        close_q;

  assign tick_nx = {1'b0, tick_cnt} + 17'd1;
  assign closing = sec_tick && (tick_nx >= {1'b0, period_len});

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
      close_q  <= 1'b0;
    end else begin
      close_q <= closing;
      if (closing)       tick_cnt <= '0;
      else if (sec_tick) tick_cnt <= tick_nx[15:0];
    end
  end

  // record intake
  logic acc;
  assign in_ready = !close_q;
  assign acc      = in_valid && in_ready;

  logic [TW-1:0] inj_tot, llc_tot, mlc_tot;
  logic          inj_gt, llc_leak_gt, mlc_ant_gt, llc_ant_gt;

  assign inj_tot = TW'(in_inj_hit) + TW'(in_inj_miss);
  assign llc_tot = TW'(in_llc_hit) + TW'(in_llc_miss);
  assign mlc_tot = TW'(in_mlc_hit) + TW'(in_mlc_miss);

  lam_ratio_cmp #(.W(TW)) u_cmp_inj (
    .part(TW'(in_inj_miss)), .whole(inj_tot), .thr(thr_inj), .gt(inj_gt));
  lam_ratio_cmp #(.W(TW)) u_cmp_llc_leak (
    .part(TW'(in_llc_miss)), .whole(llc_tot), .thr(thr_llc), .gt(llc_leak_gt));
  lam_ratio_cmp #(.W(TW)) u_cmp_mlc_ant (
    .part(TW'(in_mlc_miss)), .whole(mlc_tot), .thr(thr_ant), .gt(mlc_ant_gt));
  lam_ratio_cmp #(.W(TW)) u_cmp_llc_ant (
    .part(TW'(in_llc_miss)), .whole(llc_tot), .thr(thr_ant), .gt(llc_ant_gt));

  logic [NSRC-1:0]          t_seen, t_sto, t_leak, t_ant;
  logic [NSRC-1:0][IOW-1:0] t_io;

  lam_src_table #(.NSRC(NSRC), .IOW(IOW), .SW(SW)) u_table (
    .clk(clk), .rst(rst), .clear(close_q), .wr(acc), .src(in_src),
    .sto_in(in_storage), .leak_in(inj_gt && llc_leak_gt),
    .ant_in(mlc_ant_gt && llc_ant_gt), .io_in(in_io),
    .seen(t_seen), .sto(t_sto), .leak_c(t_leak), .ant_c(t_ant), .io(t_io));

  // system throughput share
  logic [SUMW-1:0] io_sum, sto_sum;
  logic            share_gt;

  always_comb begin
    io_sum  = '0;
    sto_sum = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (t_seen[i]) begin
        io_sum = io_sum + SUMW'(t_io[i]);
        if (t_sto[i]) sto_sum = sto_sum + SUMW'(t_io[i]);
      end
    end
  end

  lam_ratio_cmp #(.W(SUMW)) u_cmp_share (
    .part(sto_sum), .whole(io_sum), .thr(thr_io), .gt(share_gt));

  // phase control and flag update
  logic probe;

  lam_phase_ctl u_phase (
    .clk(clk), .rst(rst), .close(close_q),
    .stable_len(stable_len), .probe_len(probe_len), .probe(probe));

  assign revert_part = probe;

  always_ff @(posedge clk) begin
    if (rst) begin
      leak_flag  <= '0;
      antag_flag <= '0;
    end else if (close_q && !probe) begin
      leak_flag  <= t_seen & t_sto & t_leak & {NSRC{share_gt}};
      antag_flag <= t_seen & t_ant;
    end
  end

  // R5: flags move only right after an evaluation cycle
  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(close_q) |-> ($stable(leak_flag) && $stable(antag_flag)));
  // R7: closing a probe period leaves the flags untouched
  assert_probe_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(close_q) && $past(probe)) |-> ($stable(leak_flag) && $stable(antag_flag)));
  // R4: an empty injection window cannot qualify
  assert_zero_never_flags_R4: assert property (@(posedge clk) disable iff (rst)
    (acc && (inj_tot == '0)) |-> !inj_gt);
  // R2: no storage throughput means no leak flag
  assert_no_storage_no_leak_R2: assert property (@(posedge clk) disable iff (rst)
    (close_q && !probe && (sto_sum == '0)) |=> (leak_flag == '0));
endmodule

// File: tb/lam_leak_monitor_bench.sv
module lam_leak_monitor_bench;
  localparam int CLK_PER = 10;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_tick = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_src = '0;
  logic in_storage = 1'b0;
  logic [7:0] in_llc_hit = '0, in_llc_miss = '0, in_mlc_hit = '0, in_mlc_miss = '0;
  logic [7:0] in_inj_hit = '0, in_inj_miss = '0, in_io = '0;
  logic [NS-1:0] leak_flag, antag_flag;
  logic revert_part;

  lam_leak_monitor #(.NSRC(NS), .CW(8), .IOW(8)) u_lam_leak_monitor (
    .clk(clk), .rst(rst), .sec_tick(sec_tick),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src),
    .in_storage(in_storage),
    .in_llc_hit(in_llc_hit), .in_llc_miss(in_llc_miss),
    .in_mlc_hit(in_mlc_hit), .in_mlc_miss(in_mlc_miss),
    .in_inj_hit(in_inj_hit), .in_inj_miss(in_inj_miss), .in_io(in_io),
    .leak_flag(leak_flag), .antag_flag(antag_flag), .revert_part(revert_part));

  always #(CLK_PER/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  bit m_seen[NS];
  bit m_sto[NS];
  int m_lh[NS], m_lm[NS], m_mh[NS], m_mm[NS], m_ih[NS], m_im[NS], m_io[NS];
  int t_inj = 40, t_llc = 40, t_io = 35, t_ant = 90;
  logic [NS-1:0] exp_leak = '0, exp_ant = '0;

  function automatic bit over(int part, int whole, int thr);
    return (part * 100) > (thr * whole);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NS; i++) m_seen[i] = 1'b0;
  endtask

  task automatic cfg(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      0: t_inj = d & 127;
      1: t_llc = d & 127;
      2: t_io  = d & 127;
      3: t_ant = d & 127;
      default: ;
    endcase
  endtask

  task automatic drive(int s, bit st, int lh, int lm, int mh, int mm, int ih, int im, int io);
    in_valid = 1'b1; in_src = 2'(s); in_storage = st;
    in_llc_hit = 8'(lh); in_llc_miss = 8'(lm);
    in_mlc_hit = 8'(mh); in_mlc_miss = 8'(mm);
    in_inj_hit = 8'(ih); in_inj_miss = 8'(im); in_io = 8'(io);
    m_seen[s] = 1'b1; m_sto[s] = st;
    m_lh[s] = lh; m_lm[s] = lm; m_mh[s] = mh; m_mm[s] = mm;
    m_ih[s] = ih; m_im[s] = im; m_io[s] = io;
  endtask

  task automatic put(int s, bit st, int lh, int lm, int mh, int mm, int ih, int im, int io);
    @(negedge clk);
    drive(s, st, lh, lm, mh, mm, ih, im, io);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic model_eval();
    int tot, stsum;
    bit share;
    tot = 0; stsum = 0;
    for (int i = 0; i < NS; i++) begin
      if (m_seen[i]) begin
        tot += m_io[i];
        if (m_sto[i]) stsum += m_io[i];
      end
    end
    share = over(stsum, tot, t_io);
    for (int i = 0; i < NS; i++) begin
      exp_leak[i] = m_seen[i] && m_sto[i] && share &&
                    over(m_im[i], m_ih[i] + m_im[i], t_inj) &&
                    over(m_lm[i], m_lh[i] + m_lm[i], t_llc);
      exp_ant[i]  = m_seen[i] &&
                    over(m_mm[i], m_mh[i] + m_mm[i], t_ant) &&
                    over(m_lm[i], m_lh[i] + m_lm[i], t_ant);
    end
  endtask

  // tick already driven at the last negedge; finish the close and check
  task automatic finish_close(string req, bit upd, logic [NS-1:0] ol, logic [NS-1:0] oa);
    if (upd) model_eval();
    else begin exp_leak = ol; exp_ant = oa; end
    @(negedge clk);
    sec_tick = 1'b0; in_valid = 1'b0;
    check(in_ready == 1'b0, "R8", int'(in_ready), 0);
    check(leak_flag == ol && antag_flag == oa, "R5", int'({leak_flag, antag_flag}), int'({ol, oa}));
    @(negedge clk);
    check(leak_flag == exp_leak, req, int'(leak_flag), int'(exp_leak));
    check(antag_flag == exp_ant, req, int'(antag_flag), int'(exp_ant));
    model_clear();
  endtask

  task automatic close_chk(string req, bit upd);
    logic [NS-1:0] ol, oa;
    @(negedge clk);
    ol = leak_flag; oa = antag_flag;
    sec_tick = 1'b1;
    finish_close(req, upd, ol, oa);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_inj = 40; t_llc = 40; t_io = 35; t_ant = 90;
    exp_leak = '0; exp_ant = '0;
    model_clear();
  endtask

  initial begin
    #(CLK_PER * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    model_clear();
    do_reset();
    @(negedge clk);
    check(leak_flag == '0, "R9", int'(leak_flag), 0);
    check(antag_flag == '0, "R9", int'(antag_flag), 0);
    check(revert_part == 1'b0, "R9", int'(revert_part), 0);
    check(in_ready == 1'b1, "R9", int'(in_ready), 1);

    cfg(5, 16'hFFFF);

    // R1: injection-way miss sweep at the reset threshold
    for (int m = 0; m <= 100; m++) begin
      put(0, 1, 50, 50, 100, 0, 100 - m, m, 100);
      put(1, 0, 0, 0, 0, 0, 0, 0, 100);
      close_chk("R1", 1);
    end
    // R1: LLC miss sweep
    for (int m = 0; m <= 100; m++) begin
      put(0, 1, 100 - m, m, 100, 0, 0, 100, 100);
      put(1, 0, 0, 0, 0, 0, 0, 0, 100);
      close_chk("R1", 1);
    end
    // R2: storage share sweep, two storage sources
    for (int s = 0; s <= 100; s++) begin
      put(0, 1, 0, 100, 100, 0, 0, 100, s);
      put(2, 1, 0, 100, 100, 0, 0, 100, 0);
      put(1, 0, 0, 0, 0, 0, 0, 0, 100 - s);
      close_chk("R2", 1);
    end
    // R3: MLC x LLC miss grid around 90
    for (int a = 85; a <= 95; a++) begin
      for (int b = 85; b <= 95; b++) begin
        put(2, 0, 100 - b, b, 100 - a, a, 0, 0, 10);
        put(3, 1, 100 - b, b, 100 - a, a, 100, 0, 10);
        close_chk("R3", 1);
      end
    end
    // R8: later record for the same source replaces the earlier one
    put(0, 1, 0, 100, 0, 100, 0, 100, 100);
    close_chk("R8", 1);
    put(0, 1, 0, 100, 0, 100, 0, 100, 100);
    put(0, 1, 100, 0, 100, 0, 100, 0, 100);
    close_chk("R8", 1);
    // R8: record in the cycle of the closing pulse counts
    begin
      logic [NS-1:0] ol, oa;
      @(negedge clk);
      ol = leak_flag; oa = antag_flag;
      drive(1, 1, 0, 100, 0, 100, 0, 100, 50);
      sec_tick = 1'b1;
      finish_close("R8", 1, ol, oa);
    end
    // R5: a record between closes does not move the flags
    put(1, 1, 100, 0, 100, 0, 100, 0, 50);
    @(negedge clk);
    check(leak_flag == 4'b0010, "R5", int'(leak_flag), 2);
    check(antag_flag == 4'b0010, "R5", int'(antag_flag), 2);
    close_chk("R5", 1);

    // R10: three pulses per period
    cfg(4, 3);
    put(3, 1, 0, 100, 0, 100, 0, 100, 40);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      @(negedge clk);
      check(in_ready == 1'b1, "R10", int'(in_ready), 1);
      check(leak_flag == '0, "R10", int'(leak_flag), 0);
    end
    close_chk("R10", 1);
    check(leak_flag == 4'b1000, "R10", int'(leak_flag), 8);
    cfg(4, 1);

    // R4: zero accesses with zero thresholds
    cfg(0, 0); cfg(1, 0); cfg(2, 0); cfg(3, 0);
    put(0, 1, 0, 0, 0, 0, 0, 0, 50);
    put(1, 1, 0, 1, 0, 1, 0, 1, 50);
    close_chk("R4", 1);
    check(leak_flag[0] == 1'b0 && leak_flag[2] == 1'b0, "R4", int'(leak_flag), 2);
    check(antag_flag == 4'b0010, "R4", int'(antag_flag), 2);

    // R6 / R7: reset-value probe cadence
    do_reset();
    for (int p = 1; p <= 10; p++) begin
      put(0, 1, 0, 100, 0, 0, 0, 100, 100);
      close_chk("R6", 1);
      check(revert_part == (p == 10), "R6", int'(revert_part), int'(p == 10));
    end
    check(leak_flag == 4'b0001, "R6", int'(leak_flag), 1);
    put(0, 1, 100, 0, 100, 0, 100, 0, 100);
    close_chk("R7", 0);
    check(revert_part == 1'b0, "R6", int'(revert_part), 0);
    put(0, 1, 100, 0, 100, 0, 100, 0, 100);
    close_chk("R7", 1);
    check(leak_flag == 4'b0000, "R7", int'(leak_flag), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule